// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Synchronized Start

This block is an 8-bit down-counter for a small microcontroller peripheral set. It decrements once for each active edge of a chosen count source. That source is either an internal prescaled clock, which advances the counter on its rising edge, or an external pin, which advances it on its falling edge. When the counter is at zero, the next active edge raises a one-cycle underflow pulse. On that same edge the counter reloads from a reload register. Everything runs on one system clock, and source edges reach the counter only as single-cycle enables.

Software starts and stops the timer through write strobes. The reload value may be written at any time. The live count may be written, and the source select changed, only while the timer is stopped. Writes of either kind made while the timer runs are dropped. The count reads back only while the timer is stopped.

Counting starts on an edge of the source, not at the moment of the start write. A start writes the control state machine from STOPPED into ARMING, and ARMING moves to COUNTING one cycle later. Each active edge seen in COUNTING decrements the counter. Because the start can fall anywhere inside a source period, the first underflow can come up to one source period early compared with the periods that follow. The state machine has three transitions out of its normal path. START takes STOPPED to ARMING. SETTLE takes ARMING to COUNTING. HALT takes ARMING or COUNTING back to STOPPED.

Top module: `reload_timer`

## Requirements
- R1: After reset the timer is stopped (`running`=0), `underflow`=0, the count and reload register are 0, the source select is internal, and `rd_data` reads 0.
- R2: A count write (`cnt_wr`) while stopped loads `cnt_data` into the count. A count write while the timer runs has no effect on the count.
- R3: `rd_data` shows the count while the timer is stopped and reads 0 while it runs.
- R4: A start write (`run_wr`=1, `run_val`=1) moves STOPPED to ARMING, and `running` goes to 1. ARMING ignores source edges and moves to COUNTING on the next cycle. The first edge in COUNTING decrements, so a count N gives its first underflow on edge N+1.
- R5: With the internal source selected (select value 0), each rising edge of `src_int` decrements a nonzero count by one. Falling edges do nothing.
- R6: With the external source selected (select value 1), `src_ext` passes through a two-flop synchronizer. Each falling edge decrements the count, and rising edges and `src_int` do nothing.
- R7: An active edge while the count is 0 gives `underflow`=1 for exactly one cycle and reloads the count from the reload register. A reload value R therefore gives one underflow every R+1 edges.
- R8: A reload write (`rld_wr`) is accepted at any time. When it falls in the same cycle as an underflow reload, the count takes the newly written value.
- R9: A source-select write (`sel_wr`, `sel_val`) takes effect only while stopped. While the timer runs, such writes are dropped.
- R10: A stop write (`run_wr`=1, `run_val`=0) returns to STOPPED. This takes priority over a coincident edge. While stopped the count holds and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_int | input | 1 | Internal prescaled count source (rising edge active) |
| src_ext | input | 1 | External count pin, asynchronous (falling edge active) |
| run_wr | input | 1 | Control write strobe |
| run_val | input | 1 | 1 = start, 0 = stop |
| sel_wr | input | 1 | Source-select write strobe |
| sel_val | input | 1 | 0 = internal source, 1 = external pin |
| rld_wr | input | 1 | Reload register write strobe |
| rld_data | input | WIDTH | Reload value |
| cnt_wr | input | 1 | Count write strobe (stopped only) |
| cnt_data | input | WIDTH | Count value to write |
| rd_data | output | WIDTH | Count readback (0 while running) |
| running | output | 1 | Timer is in ARMING or COUNTING |
| underflow | output | 1 | One-cycle underflow pulse |

## Verification
The bench drives the timer with trains of internal-source pulses at several written counts and reload values. Each pulse is checked for whether it alone produces an underflow. This separates a first edge that decrements from one that only arms the counter, and it pins down the reload period. Falling-edge trains on the external pin are run against internal pulses sent while the external pin is selected, to show which edge polarity and which source count. A reload write placed in the exact cycle of an underflow is told apart from a mid-count write by the length of the following period. Stop, and count and select writes made while running, are each followed by a readback or a pulse train that would expose any change.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        TS_STOP = 2'd0,
        TS_ARM  = 2'd1,
        TS_RUN  = 2'd2
    } tmr_state_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_sel_e;
endpackage

// File: rtl/rt_sync.sv
module rt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rt_edge_sel.sv
module rt_edge_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_int,
    input  logic             src_ext,
    input  rt_pkg::src_sel_e sel,
    output logic             edge_o
);
    import rt_pkg::*;

    logic int_q, int_prev;
    logic ext_s, ext_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q    <= 1'b0;
            int_prev <= 1'b0;
            ext_prev <= 1'b0;
        end else begin
            int_q    <= src_int;
            int_prev <= int_q;
            ext_prev <= ext_s;
        end
    end

    rt_sync #(.STAGES(SYNC_STAGES)) ext_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (src_ext),
        .q    (ext_s)
    );

    always_comb begin
        unique case (sel)
            SRC_INT: edge_o = int_q & ~int_prev;
            SRC_EXT: edge_o = ext_prev & ~ext_s;
            default: edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rt_ctrl_fsm.sv
module rt_ctrl_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_wr,
    input  logic               run_val,
    output rt_pkg::tmr_state_e state_o,
    output logic               running_o,
    output logic               count_en_o
);
    import rt_pkg::*;

    tmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_STOP: if (run_wr && run_val)  state_d = TS_ARM;   // START
            TS_ARM:  if (run_wr && !run_val) state_d = TS_STOP;  // HALT
                     else                    state_d = TS_RUN;   // SETTLE
            TS_RUN:  if (run_wr && !run_val) state_d = TS_STOP;  // HALT
            default:                         state_d = TS_STOP;
        endcase
    end

    always_comb begin
        running_o  = 1'b0;
        count_en_o = 1'b0;
        unique case (state_q)
            TS_STOP: ;
            TS_ARM:  running_o = 1'b1;
            TS_RUN: begin
                running_o  = 1'b1;
                count_en_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_int,
    input  logic             src_ext,
    input  logic             run_wr,
    input  logic             run_val,
    input  logic             sel_wr,
    input  logic             sel_val,
    input  logic             rld_wr,
    input  logic [WIDTH-1:0] rld_data,
    input  logic             cnt_wr,
    input  logic [WIDTH-1:0] cnt_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             running,
    output logic             underflow
);
    import rt_pkg::*;

    localparam logic [WIDTH-1:0] CNT_ZERO = '0;
    localparam logic [WIDTH-1:0] CNT_ONE  = WIDTH'(1);

    tmr_state_e       state;
    src_sel_e         sel_q;
    logic             count_en, src_edge, stop_req;
    logic [WIDTH-1:0] count_q, reload_q;
    logic             uf_q;

    rt_ctrl_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_wr    (run_wr),
        .run_val   (run_val),
        .state_o   (state),
        .running_o (running),
        .count_en_o(count_en)
    );

    rt_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_int(src_int),
        .src_ext(src_ext),
        .sel    (sel_q),
        .edge_o (src_edge)
    );

    assign stop_req = run_wr && !run_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= CNT_ZERO;
            reload_q <= CNT_ZERO;
            sel_q    <= SRC_INT;
            uf_q     <= 1'b0;
        end else begin
            uf_q <= 1'b0;
            if (rld_wr) reload_q <= rld_data;
            if (!running && sel_wr) sel_q <= src_sel_e'(sel_val);
            if (!running && cnt_wr) begin
                count_q <= cnt_data;
            end else if (count_en && src_edge && !stop_req) begin
                if (count_q == CNT_ZERO) begin
                    uf_q    <= 1'b1;
                    count_q <= rld_wr ? rld_data : reload_q;
                end else begin
                    count_q <= count_q - CNT_ONE;
                end
            end
        end
    end

    assign underflow = uf_q;
    assign rd_data   = running ? CNT_ZERO : count_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_wr,
    input logic               run_val,
    input logic               cnt_wr,
    input logic               rld_wr,
    input logic [WIDTH-1:0]   rld_data,
    input logic               underflow,
    input rt_pkg::tmr_state_e state,
    input rt_pkg::src_sel_e   sel_q,
    input logic               src_edge,
    input logic [WIDTH-1:0]   count_q,
    input logic [WIDTH-1:0]   reload_q
);
    import rt_pkg::*;

    AST_UF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);  // R7

    AST_RELOAD_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> count_q == ($past(rld_wr) ? $past(rld_data) : $past(reload_q)));  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_STOP) |=> !underflow);  // R10

    AST_SEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TS_STOP) |=> $stable(sel_q));  // R9

    AST_CNT_WR_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TS_STOP && cnt_wr && !src_edge) |=> $stable(count_q));  // R2

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_RUN && src_edge && !(run_wr && !run_val) && count_q != '0)
        |=> count_q == $past(count_q) - WIDTH'(1));  // R5

    AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_ARM) |=> $stable(count_q));  // R4

    AST_ARM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_ARM && !(run_wr && !run_val)) |=> state == TS_RUN);  // R4
endmodule

bind reload_timer rt_checker #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_wr   (run_wr),
    .run_val  (run_val),
    .cnt_wr   (cnt_wr),
    .rld_wr   (rld_wr),
    .rld_data (rld_data),
    .underflow(underflow),
    .state    (state),
    .sel_q    (sel_q),
    .src_edge (src_edge),
    .count_q  (count_q),
    .reload_q (reload_q)
);

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         src_int = 1'b0, src_ext = 1'b1;
    logic         run_wr = 1'b0, run_val = 1'b0;
    logic         sel_wr = 1'b0, sel_val = 1'b0;
    logic         rld_wr = 1'b0, cnt_wr = 1'b0;
    logic [W-1:0] rld_data = '0, cnt_data = '0;
    logic [W-1:0] rd_data;
    logic         running, underflow;

    int    vectors = 0;
    int    miscompares = 0;
    int    uf_seen = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    event  win_ev;

    always #10 clk = ~clk;  // 50 MHz

    reload_timer #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_int(src_int), .src_ext(src_ext),
        .run_wr(run_wr), .run_val(run_val), .sel_wr(sel_wr), .sel_val(sel_val),
        .rld_wr(rld_wr), .rld_data(rld_data), .cnt_wr(cnt_wr), .cnt_data(cnt_data),
        .rd_data(rd_data), .running(running), .underflow(underflow)
    );

    // monitor: counts underflow cycles, compares at each window end
    always @(negedge clk) if (underflow === 1'b1) uf_seen++;

    initial begin
        forever begin
            @(win_ev);
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (uf_seen != e) begin
                    miscompares++;
                    $display("FAIL %s: underflow cycles actual %0d expected %0d", t, uf_seen, e);
                end
            end
            uf_seen = 0;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic close_win(input int e, input string tag);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->win_ev;
    endtask

    task automatic wr_run(input logic v);
        @(negedge clk); run_wr = 1'b1; run_val = v;
        @(negedge clk); run_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic v);
        @(negedge clk); sel_wr = 1'b1; sel_val = v;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [W-1:0] d);
        @(negedge clk); cnt_wr = 1'b1; cnt_data = d;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_rld(input logic [W-1:0] d);
        @(negedge clk); rld_wr = 1'b1; rld_data = d;
        @(negedge clk); rld_wr = 1'b0;
    endtask

    task automatic int_edge(input int e, input string tag);
        @(negedge clk); src_int = 1'b1;
        repeat (3) @(negedge clk);
        src_int = 1'b0;
        repeat (3) @(negedge clk);
        close_win(e, tag);
    endtask

    // rising edge with a reload write landing in the counter's update cycle
    task automatic int_edge_rld(input int e, input logic [W-1:0] d, input string tag);
        @(negedge clk); src_int = 1'b1;
        @(negedge clk); rld_wr = 1'b1; rld_data = d;
        @(negedge clk); rld_wr = 1'b0;
        @(negedge clk); src_int = 1'b0;
        repeat (3) @(negedge clk);
        close_win(e, tag);
    endtask

    task automatic ext_edge(input int e, input string tag);
        @(negedge clk); src_ext = 1'b0;
        repeat (4) @(negedge clk);
        src_ext = 1'b1;
        repeat (4) @(negedge clk);
        close_win(e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(running, 0, "R1 running");
        chk(underflow, 0, "R1 underflow");
        chk(rd_data, 0, "R1 rd_data");

        wr_cnt(8'h5A);
        chk(rd_data, 8'h5A, "R2 count write stopped");

        // first edge after start decrements; reload period
        wr_cnt(8'd2);
        wr_rld(8'd1);
        wr_run(1'b1);
        chk(running, 1, "R4 running after start");
        chk(rd_data, 0, "R3 rd_data zero while running");
        int_edge(0, "R4 first edge 2->1");
        int_edge(0, "R5 edge 1->0");
        int_edge(1, "R7 underflow at 0");
        int_edge(0, "R7 reload 1 -> 0");
        int_edge(1, "R7 period of 2");

        // reload write in the underflow cycle: new value wins
        int_edge(0, "R8 1->0");
        int_edge_rld(1, 8'd3, "R8 underflow with coincident write");
        int_edge(0, "R8 loaded 3 ->2");
        int_edge(0, "R8 2->1");
        int_edge(0, "R8 1->0");
        int_edge(1, "R8 new period 4");

        // mid-count reload write, takes effect at next underflow
        wr_rld(8'd0);
        int_edge(0, "R8 3->2");
        int_edge(0, "R8 2->1");
        int_edge(0, "R8 1->0");
        int_edge(1, "R8 underflow loads 0");
        int_edge(1, "R7 reload 0 every edge");

        // stop, count write ignored while running
        wr_run(1'b0);
        chk(running, 0, "R10 stopped");
        wr_cnt(8'd4);
        wr_rld(8'd7);
        wr_run(1'b1);
        int_edge(0, "R5 4->3");
        wr_cnt(8'd9);
        chk(rd_data, 0, "R3 read while running");
        wr_run(1'b0);
        chk(rd_data, 3, "R2 running count write ignored");
        int_edge(0, "R10 no count while stopped");
        chk(rd_data, 3, "R10 count holds");

        // external source, falling edge
        wr_sel(1'b1);
        wr_cnt(8'd1);
        wr_rld(8'd1);
        wr_run(1'b1);
        int_edge(0, "R6 internal ignored when external selected");
        ext_edge(0, "R6 fall 1->0");
        ext_edge(1, "R6 underflow on fall");
        ext_edge(0, "R6 1->0");
        ext_edge(1, "R6 period 2");

        // select write while running is dropped
        wr_sel(1'b0);
        int_edge(0, "R9 internal still ignored");
        ext_edge(0, "R9 external still counts 1->0");
        ext_edge(1, "R9 external underflow");
        wr_run(1'b0);
        wr_sel(1'b0);
        wr_run(1'b1);
        ext_edge(0, "R9 external ignored after stopped switch");
        int_edge(0, "R9 internal 1->0");
        int_edge(1, "R9 internal underflow");

        repeat (4) @(negedge clk);
        chk(exp_q.size(), 0, "R7 scoreboard drained");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule